// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic datapath of a small 8-bit controller core together with the status register that sits beside it. On each execute strobe it combines the accumulator and a file operand under a 3-bit operation code, registers the result, and optionally refreshes the carry, digit-carry and zero flags. Arithmetic operations refresh all three flags; logic and pass operations refresh only zero.

The same register also keeps two housekeeping flags that software reads to learn why the core woke up: a power-down flag and a time-out flag. Reset, a watchdog-clear instruction, a sleep instruction and a watchdog overflow each move them in a fixed way. The three arithmetic flags can also be loaded by a register write. The two event flags ignore such writes, and the top three status bits always read as zero.

Top module: `alu_flag_unit`

## Requirements
- R1: Opcode 3'd1 (add) gives result = file + acc mod 256, with carry (status bit 0) = carry out of bit 7 and digit carry (status bit 1) = carry out of bit 3.
- R2: Opcode 3'd2 (subtract) gives result = file - acc mod 256, computed as file + ~acc + 1. Carry is 1 when file >= acc (no borrow). Digit carry is 1 when file[3:0] >= acc[3:0].
- R3: On an execute with the flag enable high, the zero flag (status bit 2) becomes 1 exactly when the new result is zero, for every opcode.
- R4: Opcodes 3'd0 (pass file), 3'd3 (and), 3'd4 (or), 3'd5 (xor), 3'd6 (invert file) and 3'd7 (pass acc) update only zero; carry and digit carry keep their values.
- R5: An execute with the flag enable low updates the result but leaves status bits 2:0 unchanged.
- R6: A status write loads bits 2:0 from the write data. Bits 4:3 are not affected by it, and bits 7:5 always read 0.
- R7: When a status write and a flag-enabled execute fall in the same cycle, the ALU wins on every flag the operation updates; the written values land on the remaining flags.
- R8: Reset is synchronous and active high. Afterwards the status reads 8'h18 (power-down = 1, time-out = 1, other bits 0) and the result reads 0.
- R9: A sleep strobe clears power-down (bit 3) and sets time-out (bit 4).
- R10: A watchdog-clear strobe sets both power-down and time-out.
- R11: A watchdog-overflow strobe clears time-out and does not change power-down. For time-out it overrides a sleep or clear strobe in the same cycle; for power-down, sleep overrides clear.
- R12: Result and status are registered, so each change shows on the outputs one clock after the strobe that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| acc_i | input | 8 | Accumulator operand |
| file_i | input | 8 | File register operand |
| op_i | input | 3 | Operation code |
| exec_i | input | 1 | Execute strobe |
| flag_en_i | input | 1 | Allow the execute to update flags |
| stat_wr_i | input | 1 | Status register write strobe |
| stat_wdata_i | input | 3 | Write data for status bits 2:0 |
| wdt_clr_i | input | 1 | Watchdog-clear instruction event |
| sleep_i | input | 1 | Sleep instruction event |
| wdt_ovf_i | input | 1 | Watchdog overflow event |
| result_o | output | 8 | Registered ALU result |
| status_o | output | 8 | Status byte |

## Verification
Add is tried with operands that carry only out of the low nibble, only out of bit 7, both ways, and to an exact zero. These cases separate the digit-carry path from the carry path and show that zero follows the result. Subtract is tried with file above, equal to and below acc, and with nibble-only borrows, which exposes a borrow that is not inverted. Logic ops run after flags were set to known opposite values, so any unwanted update of carry shows. The event strobes are driven alone and in colliding pairs, which pins down the override order between them.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  typedef enum logic [2:0] {
    OP_PASS_F = 3'd0,
    OP_ADD    = 3'd1,
    OP_SUB    = 3'd2,
    OP_AND    = 3'd3,
    OP_OR     = 3'd4,
    OP_XOR    = 3'd5,
    OP_NOT_F  = 3'd6,
    OP_PASS_A = 3'd7
  } alu_op_e;

  localparam int STAT_C  = 0;
  localparam int STAT_DC = 1;
  localparam int STAT_Z  = 2;
  localparam int STAT_PD = 3;
  localparam int STAT_TO = 4;
  localparam int STAT_W  = 8;
endpackage

// File: rtl/alu_core.sv
module alu_core
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] file_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         dc_o,
  output logic         arith_o
);
  localparam int H = W / 2;

  logic         is_sub;
  logic [W-1:0] b_opnd;
  logic [W:0]   full_sum;
  logic [H:0]   half_sum;

  assign is_sub   = (op_i == OP_SUB);
  assign b_opnd   = is_sub ? ~acc_i : acc_i;
  assign full_sum = {1'b0, file_i} + {1'b0, b_opnd} + {{W{1'b0}}, is_sub};
  assign half_sum = {1'b0, file_i[H-1:0]} + {1'b0, b_opnd[H-1:0]} + {{H{1'b0}}, is_sub};
  assign c_o      = full_sum[W];
  assign dc_o     = half_sum[H];
  assign arith_o  = (op_i == OP_ADD) || is_sub;

  always_comb begin
    unique case (op_i)
      OP_ADD, OP_SUB: res_o = full_sum[W-1:0];
      OP_AND:         res_o = file_i & acc_i;
      OP_OR:          res_o = file_i | acc_i;
      OP_XOR:         res_o = file_i ^ acc_i;
      OP_NOT_F:       res_o = ~file_i;
      OP_PASS_A:      res_o = acc_i;
      default:        res_o = file_i;
    endcase
  end
endmodule

// File: rtl/arith_flags.sv
module arith_flags (
  input  logic       clk,
  input  logic       rst,
  input  logic       upd_arith_i,
  input  logic       upd_z_i,
  input  logic       c_i,
  input  logic       dc_i,
  input  logic       z_i,
  input  logic       wr_i,
  input  logic [2:0] wdata_i,
  output logic       c_o,
  output logic       dc_o,
  output logic       z_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      c_o  <= 1'b0;
      dc_o <= 1'b0;
      z_o  <= 1'b0;
    end else begin
      if (upd_arith_i) begin
        c_o  <= c_i;
        dc_o <= dc_i;
      end else if (wr_i) begin
        c_o  <= wdata_i[0];
        dc_o <= wdata_i[1];
      end
      if (upd_z_i)   z_o <= z_i;
      else if (wr_i) z_o <= wdata_i[2];
    end
  end
endmodule

// File: rtl/power_flags.sv
module power_flags (
  input  logic clk,
  input  logic rst,
  input  logic wdt_clr_i,
  input  logic sleep_i,
  input  logic wdt_ovf_i,
  output logic pd_o,
  output logic to_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pd_o <= 1'b1;
      to_o <= 1'b1;
    end else begin
      if (sleep_i)        pd_o <= 1'b0;
      else if (wdt_clr_i) pd_o <= 1'b1;

      if (wdt_ovf_i)                 to_o <= 1'b0;
      else if (sleep_i || wdt_clr_i) to_o <= 1'b1;
    end
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] file_i,
  input  logic [2:0]   op_i,
  input  logic         exec_i,
  input  logic         flag_en_i,
  input  logic         stat_wr_i,
  input  logic [2:0]   stat_wdata_i,
  input  logic         wdt_clr_i,
  input  logic         sleep_i,
  input  logic         wdt_ovf_i,
  output logic [W-1:0] result_o,
  output logic [7:0]   status_o
);
  logic [W-1:0] alu_res;
  logic         alu_c, alu_dc, alu_arith;
  logic         upd_z, upd_arith;
  logic         c_q, dc_q, z_q, pd_q, to_q;

  alu_core #(.W(W)) u_core (
    .acc_i   (acc_i),
    .file_i  (file_i),
    .op_i    (op_i),
    .res_o   (alu_res),
    .c_o     (alu_c),
    .dc_o    (alu_dc),
    .arith_o (alu_arith)
  );

  assign upd_z     = exec_i && flag_en_i;
  assign upd_arith = upd_z && alu_arith;

  arith_flags u_arith (
    .clk         (clk),
    .rst         (rst),
    .upd_arith_i (upd_arith),
    .upd_z_i     (upd_z),
    .c_i         (alu_c),
    .dc_i        (alu_dc),
    .z_i         (alu_res == '0),
    .wr_i        (stat_wr_i),
    .wdata_i     (stat_wdata_i),
    .c_o         (c_q),
    .dc_o        (dc_q),
    .z_o         (z_q)
  );

  power_flags u_power (
    .clk       (clk),
    .rst       (rst),
    .wdt_clr_i (wdt_clr_i),
    .sleep_i   (sleep_i),
    .wdt_ovf_i (wdt_ovf_i),
    .pd_o      (pd_q),
    .to_o      (to_q)
  );

  always_ff @(posedge clk) begin
    if (rst)         result_o <= '0;
    else if (exec_i) result_o <= alu_res;
  end

  assign status_o = {3'b000, to_q, pd_q, z_q, dc_q, c_q};
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         exec_i,
  input logic         flag_en_i,
  input logic         stat_wr_i,
  input logic         wdt_clr_i,
  input logic         sleep_i,
  input logic         wdt_ovf_i,
  input logic [W-1:0] result_o,
  input logic [7:0]   status_o
);
  assert_unused_zero_R6: assert property (@(posedge clk) disable iff (rst)
    status_o[7:5] == 3'b000);

  assert_zero_tracks_R3: assert property (@(posedge clk) disable iff (rst)
    (exec_i && flag_en_i) |=> (status_o[2] == (result_o == '0)));

  assert_flags_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!(exec_i && flag_en_i) && !stat_wr_i) |=> $stable(status_o[2:0]));

  assert_sleep_R9: assert property (@(posedge clk) disable iff (rst)
    (sleep_i && !wdt_ovf_i) |=> (!status_o[3] && status_o[4]));

  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (wdt_clr_i && !sleep_i && !wdt_ovf_i) |=> (status_o[3] && status_o[4]));

  assert_overflow_R11: assert property (@(posedge clk) disable iff (rst)
    wdt_ovf_i |=> !status_o[4]);

  assert_ovf_keeps_pd_R11: assert property (@(posedge clk) disable iff (rst)
    (wdt_ovf_i && !sleep_i && !wdt_clr_i) |=> $stable(status_o[3]));

  assert_reset_R8: assert property (@(posedge clk)
    rst |=> (status_o == 8'h18 && result_o == '0));
endmodule

bind alu_flag_unit alu_flag_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .exec_i    (exec_i),
  .flag_en_i (flag_en_i),
  .stat_wr_i (stat_wr_i),
  .wdt_clr_i (wdt_clr_i),
  .sleep_i   (sleep_i),
  .wdt_ovf_i (wdt_ovf_i),
  .result_o  (result_o),
  .status_o  (status_o)
);

// File: tb/alu_flag_unit_bench.sv
module alu_flag_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] acc = '0, fil = '0;
  logic [2:0] op = '0;
  logic       exec = 1'b0, fen = 1'b0, swr = 1'b0;
  logic [2:0] swd = '0;
  logic       clr = 1'b0, slp = 1'b0, ovf = 1'b0;
  logic [7:0] result;
  logic [7:0] status;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] m_res;
  logic m_c, m_dc, m_z, m_pd, m_to;

  alu_flag_unit u_alu_flag_unit (
    .clk(clk), .rst(rst), .acc_i(acc), .file_i(fil), .op_i(op),
    .exec_i(exec), .flag_en_i(fen), .stat_wr_i(swr), .stat_wdata_i(swd),
    .wdt_clr_i(clr), .sleep_i(slp), .wdt_ovf_i(ovf),
    .result_o(result), .status_o(status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_stat();
    return {3'b000, m_to, m_pd, m_z, m_dc, m_c};
  endfunction

  // Reference model of one execute, from the requirements
  task automatic model_exec(input logic [2:0] o, input logic [7:0] a, input logic [7:0] f,
                            input logic fe, input logic wr, input logic [2:0] wd);
    logic [8:0] s;
    logic c, dc;
    c = m_c; dc = m_dc;
    case (o)
      3'd1: begin s = f + a; m_res = s[7:0]; c = s[8]; dc = (f[3:0] + a[3:0]) > 15; end
      3'd2: begin m_res = f - a; c = (f >= a); dc = (f[3:0] >= a[3:0]); end
      3'd3: m_res = f & a;
      3'd4: m_res = f | a;
      3'd5: m_res = f ^ a;
      3'd6: m_res = ~f;
      3'd7: m_res = a;
      default: m_res = f;
    endcase
    if (wr) begin m_c = wd[0]; m_dc = wd[1]; m_z = wd[2]; end
    if (fe) begin
      m_z = (m_res == 8'h00);
      if (o == 3'd1 || o == 3'd2) begin m_c = c; m_dc = dc; end
    end
  endtask

  task automatic do_op(input string req, input logic [2:0] o, input logic [7:0] a,
                       input logic [7:0] f, input logic fe, input logic wr = 1'b0,
                       input logic [2:0] wd = 3'b000);
    op = o; acc = a; fil = f; fen = fe; exec = 1'b1; swr = wr; swd = wd;
    @(negedge clk);
    exec = 1'b0; swr = 1'b0; fen = 1'b0;
    model_exec(o, a, f, fe, wr, wd);
    chk({req, " result"}, result, m_res);
    chk({req, " status"}, status, m_stat());
  endtask

  task automatic write_stat(input string req, input logic [2:0] wd);
    swr = 1'b1; swd = wd;
    @(negedge clk);
    swr = 1'b0;
    m_c = wd[0]; m_dc = wd[1]; m_z = wd[2];
    chk(req, status, m_stat());
  endtask

  task automatic event_pulse(input string req, input logic c, input logic s, input logic o);
    clr = c; slp = s; ovf = o;
    @(negedge clk);
    clr = 1'b0; slp = 1'b0; ovf = 1'b0;
    if (s) m_pd = 1'b0; else if (c) m_pd = 1'b1;
    if (o) m_to = 1'b0; else if (s || c) m_to = 1'b1;
    chk(req, status, m_stat());
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    m_res = 0; m_c = 0; m_dc = 0; m_z = 0; m_pd = 1; m_to = 1;
    chk("R8 status", status, 8'h18);
    chk("R8 result", result, 8'h00);
  endtask

  task automatic t_add();
    do_op("R1 nibble carry", 3'd1, 8'h08, 8'h08, 1'b1);
    do_op("R1 top carry", 3'd1, 8'h80, 8'h90, 1'b1);
    do_op("R1 both carries", 3'd1, 8'hFF, 8'h01, 1'b1);
    do_op("R1 none", 3'd1, 8'h12, 8'h34, 1'b1);
    do_op("R3 add zero", 3'd1, 8'h00, 8'h00, 1'b1);
  endtask

  task automatic t_sub();
    do_op("R2 f>a", 3'd2, 8'h11, 8'h35, 1'b1);
    do_op("R2 equal", 3'd2, 8'h5A, 8'h5A, 1'b1);
    do_op("R2 f<a", 3'd2, 8'h35, 8'h11, 1'b1);
    do_op("R2 nibble borrow", 3'd2, 8'h0F, 8'h30, 1'b1);
    do_op("R2 zero minus one", 3'd2, 8'h01, 8'h00, 1'b1);
  endtask

  task automatic t_logic();
    write_stat("R6 set c dc", 3'b011);
    do_op("R4 and", 3'd3, 8'hF0, 8'h0F, 1'b1);
    do_op("R4 or", 3'd4, 8'hA0, 8'h05, 1'b1);
    do_op("R4 xor", 3'd5, 8'h3C, 8'h3C, 1'b1);
    do_op("R4 not f", 3'd6, 8'h00, 8'hFF, 1'b1);
    do_op("R4 pass a", 3'd7, 8'h77, 8'h00, 1'b1);
    do_op("R4 pass f", 3'd0, 8'h00, 8'h00, 1'b1);
    write_stat("R6 clear c dc", 3'b100);
    do_op("R4 or keeps zero c", 3'd4, 8'h01, 8'h00, 1'b1);
  endtask

  task automatic t_noflag();
    do_op("R5 add no flags", 3'd1, 8'hFF, 8'h01, 1'b0);
    do_op("R5 sub no flags", 3'd2, 8'h01, 8'h00, 1'b0);
  endtask

  task automatic t_statwr();
    event_pulse("R9 sleep first", 1'b0, 1'b1, 1'b0);
    write_stat("R6 write 7", 3'b111);
    write_stat("R6 write 0", 3'b000);
    chk("R6 upper bits", {status[7:5], 5'b0}, 8'h00);
    event_pulse("R10 restore", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_collide();
    do_op("R7 arith over write", 3'd1, 8'hFF, 8'h01, 1'b1, 1'b1, 3'b000);
    do_op("R7 logic with write", 3'd4, 8'h00, 8'h00, 1'b1, 1'b1, 3'b010);
    do_op("R7 write, no flags", 3'd1, 8'h00, 8'h00, 1'b0, 1'b1, 3'b101);
  endtask

  task automatic t_power();
    event_pulse("R9 sleep", 1'b0, 1'b1, 1'b0);
    event_pulse("R11 overflow", 1'b0, 1'b0, 1'b1);
    event_pulse("R10 clear", 1'b1, 1'b0, 1'b0);
    event_pulse("R11 ovf keeps pd", 1'b0, 1'b0, 1'b1);
    event_pulse("R11 ovf beats sleep", 1'b0, 1'b1, 1'b1);
    event_pulse("R11 ovf beats clear", 1'b1, 1'b0, 1'b1);
    event_pulse("R11 sleep beats clear", 1'b1, 1'b1, 1'b0);
    event_pulse("R10 clear again", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_latency();
    op = 3'd1; acc = 8'h01; fil = 8'hFF; fen = 1'b1; exec = 1'b1;
    @(posedge clk);
    #1;
    exec = 1'b0; fen = 1'b0;
    model_exec(3'd1, 8'h01, 8'hFF, 1'b1, 1'b0, 3'b000);
    chk("R12 after edge", result, m_res);
    @(negedge clk);
    chk("R12 held", status, m_stat());
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_noflag();
    t_statwr();
    t_collide();
    t_power();
    @(negedge clk);
    do_op("R12 setup", 3'd0, 8'h00, 8'h55, 1'b1);
    t_latency();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule